// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This block is an iterative integer divider for a processor's multiply/divide datapath. It takes two XLEN-bit operands and a 2-bit function code. It returns a quotient or a remainder, with the operands treated as signed or as unsigned. A request is taken through a valid/ready handshake. The block then works one quotient bit per cycle, using restoring shift-and-subtract on the operand magnitudes. A sign-correction step runs as the iteration finishes, and the result waits on a valid/ready response port.

The block never traps. A zero divisor and the one signed overflow case (the most negative value divided by minus one) each give a fixed result. These two cases skip the iteration and answer in the cycle after the request is accepted.

The controller has three states:
- ST_IDLE: ready for a request.
- ST_RUN: the iteration is in progress.
- ST_RESP: the result is held for the consumer.

It makes four transitions:
- ST_IDLE to ST_RESP, on accepting a special-case request.
- ST_IDLE to ST_RUN, on accepting any other request.
- ST_RUN to ST_RESP, once the core has produced all XLEN quotient bits.
- ST_RESP to ST_IDLE, when resp_ready is seen.

Top module: `idiv_unit`

## Requirements
- R1: Function code 2'b00 gives the signed quotient, truncated toward zero: 20/6=3, -20/6=-3, 20/-6=-3, -20/-6=3.
- R2: Function code 2'b10 gives the signed remainder, which takes the sign of the dividend: 20,6 gives 2; -20,6 gives -2; 20,-6 gives 2; -20,-6 gives -2.
- R3: Function codes 2'b01 (quotient) and 2'b11 (remainder) treat both operands as unsigned. For example, 0xffffffec/6=715827879 and 20/0xfffffffa=0. A divisor larger than the dividend gives the dividend as the remainder. 0x80000000 divided by 0xffffffff gives 0, and divided by 1 gives 0x80000000.
- R4: A zero divisor gives a quotient of all ones, in both signed and unsigned mode, whatever the dividend.
- R5: A zero divisor gives the dividend, unchanged, as the remainder, in both signed and unsigned mode.
- R6: Signed division of the most negative value by -1 gives the most negative value as the quotient and 0 as the remainder. No flag is raised.
- R7: A zero-divisor or signed-overflow request shows resp_valid in the cycle right after the accepting clock edge. Any other request shows resp_valid after XLEN+1 further clock edges.
- R8: req_ready is high only while the block is idle. A request presented while a division is in flight or a result is waiting is not taken, and it does not disturb the pending result.
- R9: Once resp_valid is high, it and resp_data stay unchanged until a clock edge with resp_ready high. After that edge, resp_valid is low and req_ready is high.
- R10: After reset, req_ready is 1, resp_valid is 0 and resp_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, so a request is taken on this edge |
| req_fn | input | 2 | Function code: bit 0 = unsigned, bit 1 = remainder |
| req_a | input | XLEN | Dividend |
| req_b | input | XLEN | Divisor |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_data | output | XLEN | Quotient or remainder |

## Verification
A 5-bit instance is swept over every dividend, divisor and function code, with the expected values worked out from integer arithmetic. This sweep covers each mix of signs, zero divisors and the overflow pair. A divider that floors instead of truncating would be off by one on mixed-sign quotients. One that gave the remainder the divisor's sign would flip -2 to 2. One that let the overflow case reach the magnitude core would return a wrapped or positive quotient. A 32-bit instance checks the stated wide values and the handshake. If the design accepted a request while busy, the pending result would be replaced. If it let the result drift before resp_ready, a changed value would be caught, as would a special case that waited the full XLEN+1 cycles.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        FN_DIV  = 2'b00,
        FN_DIVU = 2'b01,
        FN_REM  = 2'b10,
        FN_REMU = 2'b11
    } idiv_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } idiv_state_e;

    function automatic logic fn_is_signed(input idiv_fn_e f);
        return !f[0];
    endfunction

    function automatic logic fn_wants_rem(input idiv_fn_e f);
        return f[1];
    endfunction

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: magnitudes, result signs and the two fixed-result cases.
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  idiv_fn_e     fn,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         q_neg,
    output logic         r_neg,
    output logic         special,
    output logic [W-1:0] special_res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic sgn, a_neg, b_neg, zero_div, ovf;

    always_comb begin
        sgn      = fn_is_signed(fn);
        a_neg    = sgn & a[W-1];
        b_neg    = sgn & b[W-1];
        a_mag    = a_neg ? -a : a;
        b_mag    = b_neg ? -b : b;
        q_neg    = a_neg ^ b_neg;
        r_neg    = a_neg;
        zero_div = (b == '0);
        ovf      = sgn && (a == MOST_NEG) && (b == '1);
        special  = zero_div || ovf;
        if (zero_div) begin
            special_res = fn_wants_rem(fn) ? a : '1;
        end else begin
            special_res = fn_wants_rem(fn) ? '0 : MOST_NEG;
        end
    end

endmodule

// File: rtl/idiv_core.sv
// Restoring shift-subtract core: one quotient bit per step on magnitudes.
module idiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W-1:0]  diff, rem_nx, quo_nx;
    logic          ge;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        ge      = shifted >= {1'b0, dvs_q};
        diff    = shifted[W-1:0] - dvs_q;
        rem_nx  = ge ? diff : shifted[W-1:0];
        quo_nx  = {quo_q[W-2:0], ge};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= '0;
        end else if (step && !done) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);
    assign quo  = quo_q;
    assign rem  = rem_q;

    // R3: a finished magnitude remainder is always below the divisor
    p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < dvs_q));

endmodule

// File: rtl/idiv_fixup.sv
// Sign correction applied to the magnitude results.
module idiv_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         want_rem,
    output logic [W-1:0] res
);
    always_comb begin
        if (want_rem) begin
            res = r_neg ? -rem : rem;
        end else begin
            res = q_neg ? -quo : quo;
        end
    end

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_fn,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    output logic            resp_valid,
    input  logic            resp_ready,
    output logic [XLEN-1:0] resp_data
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    idiv_state_e     state_q, state_nx;
    idiv_fn_e        fn;
    logic            accept;
    logic [XLEN-1:0] a_mag, b_mag, special_res, core_quo, core_rem, fix_res, res_q;
    logic            q_neg, r_neg, special, core_done;
    logic            q_neg_q, r_neg_q, rem_sel_q;

    assign fn     = idiv_fn_e'(req_fn);
    assign accept = req_valid && req_ready;

    idiv_prep #(.W(XLEN)) u_prep (
        .a(req_a), .b(req_b), .fn(fn),
        .a_mag(a_mag), .b_mag(b_mag),
        .q_neg(q_neg), .r_neg(r_neg),
        .special(special), .special_res(special_res)
    );

    idiv_core #(.W(XLEN)) u_core (
        .clk(clk), .rst_n(rst_n),
        .load(accept && !special),
        .step(state_q == ST_RUN),
        .dividend(a_mag), .divisor(b_mag),
        .quo(core_quo), .rem(core_rem), .done(core_done)
    );

    idiv_fixup #(.W(XLEN)) u_fix (
        .quo(core_quo), .rem(core_rem),
        .q_neg(q_neg_q), .r_neg(r_neg_q), .want_rem(rem_sel_q),
        .res(fix_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_nx = special ? ST_RESP : ST_RUN;
            ST_RUN:  if (core_done)  state_nx = ST_RESP;
            ST_RESP: if (resp_ready) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        resp_data  = res_q;
    end

    // request context and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_neg_q   <= 1'b0;
            r_neg_q   <= 1'b0;
            rem_sel_q <= 1'b0;
            res_q     <= '0;
        end else begin
            if (accept) begin
                q_neg_q   <= q_neg;
                r_neg_q   <= r_neg;
                rem_sel_q <= fn_wants_rem(fn);
                if (special) res_q <= special_res;
            end
            if (state_q == ST_RUN && core_done) res_q <= fix_res;
        end
    end

    p_zero_quot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_fn[1] && req_b == '0) |=> (resp_valid && resp_data == '1));

    p_zero_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_fn[1] && req_b == '0) |=> (resp_valid && resp_data == $past(req_a)));

    p_ovf_quot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_fn == 2'b00 && req_a == MOST_NEG && req_b == '1)
        |=> (resp_valid && resp_data == MOST_NEG));

    p_ovf_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_fn == 2'b10 && req_a == MOST_NEG && req_b == '1)
        |=> (resp_valid && resp_data == '0));

    p_iter_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_fn[0] && req_b != '0) |=> (!resp_valid && !req_ready));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready) |=> (req_ready && !resp_valid));

endmodule

// File: tb/sim_idiv_unit.sv
module sim_idiv_unit;
    localparam int WB = 32;
    localparam int WS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          b_valid = 0, b_ready, b_rvalid, b_rready = 0;
    logic [1:0]    b_fn = 0;
    logic [WB-1:0] b_a = 0, b_b = 0, b_data;
    logic          s_valid = 0, s_ready, s_rvalid, s_rready = 0;
    logic [1:0]    s_fn = 0;
    logic [WS-1:0] s_a = 0, s_b = 0, s_data;

    int compared = 0;
    int mismatched = 0;

    idiv_unit #(.XLEN(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_fn(b_fn), .req_a(b_a), .req_b(b_b), .resp_valid(b_rvalid),
        .resp_ready(b_rready), .resp_data(b_data));

    idiv_unit #(.XLEN(WS)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
        .req_fn(s_fn), .req_a(s_a), .req_b(s_b), .resp_valid(s_rvalid),
        .resp_ready(s_rready), .resp_data(s_data));

    function automatic logic [31:0] ref_calc(input int w, input logic [1:0] fn,
                                             input logic [31:0] a, input logic [31:0] b);
        longint mask, ua, ub, sa, sb, q, r, mn;
        mask = (longint'(1) << w) - 1;
        ua = longint'(a) & mask;
        ub = longint'(b) & mask;
        sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
        sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
        mn = -(longint'(1) << (w-1));
        if (ub == 0) begin
            q = mask; r = ua;
        end else if (!fn[0]) begin
            if (sa == mn && sb == -1) begin q = sa; r = 0; end
            else begin q = sa / sb; r = sa % sb; end
        end else begin
            q = ua / ub; r = ua % ub;
        end
        return fn[1] ? 32'(r & mask) : 32'(q & mask);
    endfunction

    function automatic bit ref_special(input int w, input logic [1:0] fn,
                                       input logic [31:0] a, input logic [31:0] b);
        longint mask, ua, ub;
        mask = (longint'(1) << w) - 1;
        ua = longint'(a) & mask;
        ub = longint'(b) & mask;
        if (ub == 0) return 1'b1;
        return !fn[0] && ua == (longint'(1) << (w-1)) && ub == mask;
    endfunction

    function automatic string req_tag(input int w, input logic [1:0] fn,
                                      input logic [31:0] a, input logic [31:0] b);
        longint mask;
        mask = (longint'(1) << w) - 1;
        if ((longint'(b) & mask) == 0) return fn[1] ? "R5" : "R4";
        if (ref_special(w, fn, a, b)) return "R6";
        if (fn == 2'b00) return "R1";
        if (fn == 2'b10) return "R2";
        return "R3";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op_big(input logic [1:0] fn, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        b_valid = 1; b_fn = fn; b_a = a; b_b = b;
        @(negedge clk);
        b_valid = 0;
        lat = 0;
        while (!b_rvalid && lat < 200) begin @(negedge clk); lat++; end
        res = b_data;
        b_rready = 1;
        @(negedge clk);
        b_rready = 0;
    endtask

    task automatic op_small(input logic [1:0] fn, input logic [WS-1:0] a, input logic [WS-1:0] b,
                            output logic [WS-1:0] res, output int lat);
        @(negedge clk);
        s_valid = 1; s_fn = fn; s_a = a; s_b = b;
        @(negedge clk);
        s_valid = 0;
        lat = 0;
        while (!s_rvalid && lat < 200) begin @(negedge clk); lat++; end
        res = s_data;
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic check_big(input logic [1:0] fn, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] res;
        int lat;
        op_big(fn, a, b, res, lat);
        chk(req_tag(WB, fn, a, b), res, ref_calc(WB, fn, a, b));
        chk("R7", 32'(lat), ref_special(WB, fn, a, b) ? 32'd0 : 32'(WB + 1));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [31:0] first;
        logic [WS-1:0] sres;
        int slat;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", {31'd0, b_ready}, 32'd1);
        chk("R10", {31'd0, b_rvalid}, 32'd0);
        chk("R10", b_data, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R1 signed quotient truncation
        check_big(2'b00, 32'd20, 32'd6);
        check_big(2'b00, -32'sd20, 32'd6);
        check_big(2'b00, 32'd20, -32'sd6);
        check_big(2'b00, -32'sd20, -32'sd6);
        check_big(2'b00, 32'h8000_0000, 32'd1);
        // R2 signed remainder
        check_big(2'b10, 32'd20, 32'd6);
        check_big(2'b10, -32'sd20, 32'd6);
        check_big(2'b10, 32'd20, -32'sd6);
        check_big(2'b10, -32'sd20, -32'sd6);
        // R3 unsigned
        check_big(2'b01, 32'hffff_ffec, 32'd6);
        check_big(2'b01, 32'd20, 32'hffff_fffa);
        check_big(2'b11, 32'd20, 32'hffff_fffa);
        check_big(2'b11, 32'hffff_ffec, 32'hffff_fffa);
        check_big(2'b01, 32'h8000_0000, 32'hffff_ffff);
        check_big(2'b01, 32'h8000_0000, 32'd1);
        // R4 / R5 zero divisor
        check_big(2'b00, 32'h8000_0000, 32'd0);
        check_big(2'b01, 32'd1, 32'd0);
        check_big(2'b10, 32'd1, 32'd0);
        check_big(2'b11, 32'd0, 32'd0);
        check_big(2'b10, 32'h8000_0000, 32'd0);
        // R6 overflow
        check_big(2'b00, 32'h8000_0000, 32'hffff_ffff);
        check_big(2'b10, 32'h8000_0000, 32'hffff_ffff);

        // R8: requests while busy are refused and ignored
        @(negedge clk);
        b_valid = 1; b_fn = 2'b01; b_a = 32'd100; b_b = 32'd7;
        @(negedge clk);
        b_a = 32'hdead_beef; b_b = 32'd3; b_fn = 2'b11;
        chk("R8", {31'd0, b_ready}, 32'd0);
        while (!b_rvalid) @(negedge clk);
        chk("R8", {31'd0, b_ready}, 32'd0);
        b_valid = 0;
        chk("R8", b_data, 32'd14);
        b_rready = 1;
        @(negedge clk);
        b_rready = 0;
        repeat (3) @(negedge clk);
        chk("R8", {31'd0, b_rvalid}, 32'd0);

        // R9: result held until taken
        @(negedge clk);
        b_valid = 1; b_fn = 2'b00; b_a = -32'sd1000; b_b = 32'd7;
        @(negedge clk);
        b_valid = 0;
        while (!b_rvalid) @(negedge clk);
        first = b_data;
        chk("R9", first, ref_calc(WB, 2'b00, -32'sd1000, 32'd7));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", {31'd0, b_rvalid}, 32'd1);
            chk("R9", b_data, first);
        end
        b_rready = 1;
        @(negedge clk);
        b_rready = 0;
        chk("R9", {31'd0, b_rvalid}, 32'd0);
        chk("R9", {31'd0, b_ready}, 32'd1);

        // exhaustive sweep on the narrow instance
        for (int f = 0; f < 4; f++) begin
            for (int a = 0; a < (1 << WS); a++) begin
                for (int b = 0; b < (1 << WS); b++) begin
                    op_small(2'(f), WS'(a), WS'(b), sres, slat);
                    chk(req_tag(WS, 2'(f), 32'(a), 32'(b)), 32'(sres),
                        ref_calc(WS, 2'(f), 32'(a), 32'(b)));
                    chk("R7", 32'(slat),
                        ref_special(WS, 2'(f), 32'(a), 32'(b)) ? 32'd0 : 32'(WS + 1));
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule